// File: doc/BRIEF.md
# Shared-Adder CORDIC Rotator and Booth Multiplier

This block is an iterative arithmetic engine built around exactly three 22-bit adder/subtractors, one lane each for X, Y and Z. The operands are 18 bits wide. In rotation mode the engine turns a unit vector through a signed input angle, one micro-rotation per cycle. Each step uses only add, subtract, arithmetic shift and a small arctangent constant. The result is the cosine and sine of the angle. X starts at the inverse of the rotation gain, so the outputs need no scaling afterwards.

In multiply mode the same three lanes form a chain. Each lane adds one radix-4 Booth partial product (0, ±M or ±2M) into a running sum. The running sum moves right by two bits per lane, so six multiplier bits are retired per cycle. A signed 18x18 product takes three cycles instead of the roughly eighteen a bit-serial scheme needs. Around the existing adders the only additions are operand muxes and control.

A caller pulses `start_i` with `mode_i`, `op_a_i` and `op_b_i` valid. It then waits for the single-cycle `done_o`, and reads the result ports, which hold until the next accepted start.

Top module: `cordic_mul_unit`

## Requirements
- R1: While rst_ni is low and after its release, busy_o and done_o are 0 and prod_o, cos_o and sin_o are 0.
- R2: A start_i high at a rising edge while busy_o is low is accepted: op_a_i, op_b_i and mode_i (1 = multiply, 0 = rotate) are captured and busy_o is high from the next cycle.
- R3: In multiply mode prod_o equals the full 36-bit two's-complement product of op_a_i and op_b_i as signed 18-bit values, for every operand pair including -131072.
- R4: A multiply raises done_o on the third rising edge after the accepting edge, with busy_o high for the three cycles in between.
- R5: In rotate mode op_a_i is an angle where value v means v*pi/131072 rad, valid for |v| <= 65536. cos_o and sin_o are signed with 65536 = 1.0 and lie within 4 LSB of the true cosine and sine.
- R6: A rotation raises done_o on the sixteenth rising edge after the accepting edge.
- R7: done_o is high for exactly one cycle per operation, and busy_o is low whenever done_o is high.
- R8: start_i while busy_o is high is ignored: the running operation keeps its operands, mode, result and latency.
- R9: prod_o, cos_o and sin_o hold their values from done_o until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation |
| mode_i | input | 1 | 1 = multiply, 0 = rotate |
| op_a_i | input | 18 | Multiplicand, or angle in rotate mode |
| op_b_i | input | 18 | Multiplier (unused in rotate mode) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| prod_o | output | 36 | Signed product |
| cos_o | output | 18 | Cosine, 65536 = 1.0 |
| sin_o | output | 18 | Sine, 65536 = 1.0 |

## Verification
A multiply result is due on the third rising edge after the edge that accepts start_i, and a rotation result on the sixteenth. The bench drives start_i on a falling edge and then counts falling edges until done_o appears, so the count must come out as exactly 3 or 16. It samples prod_o, cos_o and sin_o one falling edge after done_o, which also confirms the pulse has dropped and the values held. A start pulsed one cycle into a running operation must leave both the count and the result untouched.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  typedef enum logic {MODE_ROT = 1'b0, MODE_MUL = 1'b1} cmu_mode_e;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_t;

  // radix-4 Booth digit from overlapping triple {b2,b1,b0}
  function automatic booth_t booth_dec(input logic [2:0] g);
    booth_t r;
    r.neg = g[2] & ~(g[1] & g[0]);
    r.one = g[1] ^ g[0];
    r.two = (g[2] & ~g[1] & ~g[0]) | (~g[2] & g[1] & g[0]);
    return r;
  endfunction
endpackage

// File: rtl/cmu_addsub.sv
module cmu_addsub #(
  parameter int W = 22
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  input  logic                sub_i,
  output logic signed [W-1:0] y_o
);
  assign y_o = a_i + (b_i ^ {W{sub_i}}) + W'(sub_i);
endmodule

// File: rtl/cmu_atan_lut.sv
module cmu_atan_lut #(
  parameter int AW = 22,
  parameter int IW = 4
) (
  input  logic [IW-1:0]        idx_i,
  output logic signed [AW-1:0] val_o
);
  localparam int SH = AW - 22;

  // atan(2^-i) with pi = 2^21
  logic signed [31:0] base;
  always_comb begin
    case (int'(idx_i))
      0:  base = 32'sd524288;
      1:  base = 32'sd309505;
      2:  base = 32'sd163534;
      3:  base = 32'sd83012;
      4:  base = 32'sd41667;
      5:  base = 32'sd20854;
      6:  base = 32'sd10430;
      7:  base = 32'sd5215;
      8:  base = 32'sd2608;
      9:  base = 32'sd1304;
      10: base = 32'sd652;
      11: base = 32'sd326;
      12: base = 32'sd163;
      13: base = 32'sd81;
      14: base = 32'sd41;
      15: base = 32'sd20;
      default: base = 32'sd0;
    endcase
  end

  generate
    if (SH >= 0) begin : g_up
      assign val_o = AW'(base <<< SH);
    end else begin : g_dn
      assign val_o = AW'(base >>> (-SH));
    end
  endgenerate
endmodule

// File: rtl/cmu_ctrl.sv
module cmu_ctrl
  import cmu_pkg::*;
#(
  parameter int ITER    = 16,
  parameter int MUL_CYC = 3,
  parameter int IW      = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  output logic          load_o,
  output logic          busy_o,
  output logic          done_o,
  output cmu_mode_e     mode_o,
  output logic [IW-1:0] iter_o
);
  logic          busy_q, done_q, last;
  cmu_mode_e     mode_q;
  logic [IW-1:0] iter_q;

  assign load_o = start_i & ~busy_q;
  assign last   = (mode_q == MODE_MUL) ? (iter_q == IW'(MUL_CYC - 1))
                                       : (iter_q == IW'(ITER - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= MODE_ROT;
      iter_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        mode_q <= cmu_mode_e'(mode_i);
        iter_q <= '0;
      end else if (busy_q) begin
        iter_q <= iter_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign mode_o = mode_q;
  assign iter_o = iter_q;

  // independent latency counter for checking
  logic [IW:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= '0;
    else if (load_o) lat_q <= '0;
    else if (busy_q) lat_q <= lat_q + 1'b1;
  end

  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (lat_q == ((mode_q == MODE_MUL) ? (IW+1)'(MUL_CYC) : (IW+1)'(ITER)))); // R4 R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q); // R7
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(mode_q)); // R8
endmodule

// File: rtl/cordic_mul_unit.sv
module cordic_mul_unit
  import cmu_pkg::*;
#(
  parameter int DW   = 18,
  parameter int ITER = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            mode_i,
  input  logic [DW-1:0]   op_a_i,
  input  logic [DW-1:0]   op_b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [2*DW-1:0] prod_o,
  output logic [DW-1:0]   cos_o,
  output logic [DW-1:0]   sin_o
);
  localparam int G       = 4;              // guard bits
  localparam int AW      = DW + G;
  localparam int NADD    = 3;
  localparam int RET     = 2 * NADD;       // multiplier bits per cycle
  localparam int MUL_CYC = (DW + RET - 1) / RET;
  localparam int IW      = $clog2(ITER);
  localparam int X0      = int'(0.6072529350088813 * (2.0 ** (DW - 2 + G)));

  logic            load, busy;
  cmu_mode_e       mode_q;
  logic [IW-1:0]   iter;

  cmu_ctrl #(.ITER(ITER), .MUL_CYC(MUL_CYC), .IW(IW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .mode_i,
    .load_o(load), .busy_o(busy), .done_o, .mode_o(mode_q), .iter_o(iter)
  );

  logic signed [AW-1:0] x_q, y_q, z_q;
  logic signed [DW-1:0] mcand_q;

  // booth digits and partial products
  logic signed [AW-1:0] m_one, m_two;
  logic signed [AW-1:0] pp [NADD];
  booth_t               dg [NADD];
  assign m_one = {{G{mcand_q[DW-1]}}, mcand_q};
  assign m_two = m_one <<< 1;

  generate
    for (genvar k = 0; k < NADD; k++) begin : g_booth
      assign dg[k] = booth_dec(z_q[2*k +: 3]);
      assign pp[k] = dg[k].two ? m_two : (dg[k].one ? m_one : '0);
    end
  endgenerate

  // rotation operands
  logic                 rot_d;
  logic signed [AW-1:0] x_sh, y_sh, atan_v;
  assign rot_d = ~z_q[AW-1];
  assign x_sh  = x_q >>> iter;
  assign y_sh  = y_q >>> iter;

  cmu_atan_lut #(.AW(AW), .IW(IW)) u_lut (.idx_i(iter), .val_o(atan_v));

  // three shared lanes
  logic                 is_mul;
  logic signed [AW-1:0] a0, a1, a2, b0, b1, b2, s0, s1, s2;
  logic                 sb0, sb1, sb2;
  assign is_mul = (mode_q == MODE_MUL);

  assign a0  = x_q;
  assign b0  = is_mul ? pp[0] : y_sh;
  assign sb0 = is_mul ? dg[0].neg : rot_d;
  assign a1  = is_mul ? (s0 >>> 2) : y_q;
  assign b1  = is_mul ? pp[1] : x_sh;
  assign sb1 = is_mul ? dg[1].neg : ~rot_d;
  assign a2  = is_mul ? (s1 >>> 2) : z_q;
  assign b2  = is_mul ? pp[2] : atan_v;
  assign sb2 = is_mul ? dg[2].neg : rot_d;

  cmu_addsub #(.W(AW)) u_add_x (.a_i(a0), .b_i(b0), .sub_i(sb0), .y_o(s0));
  cmu_addsub #(.W(AW)) u_add_y (.a_i(a1), .b_i(b1), .sub_i(sb1), .y_o(s1));
  cmu_addsub #(.W(AW)) u_add_z (.a_i(a2), .b_i(b2), .sub_i(sb2), .y_o(s2));

  // low product bits collect the two bits retired by each lane
  logic [AW-1:0] lo_nxt;
  assign lo_nxt = {{G{1'b0}}, s2[1:0], s1[1:0], s0[1:0], y_q[DW-1:RET]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q     <= '0;
      y_q     <= '0;
      z_q     <= '0;
      mcand_q <= '0;
    end else if (load) begin
      mcand_q <= op_a_i;
      y_q     <= '0;
      if (mode_i) begin
        x_q <= '0;
        z_q <= {{(G-1){op_b_i[DW-1]}}, op_b_i, 1'b0};
      end else begin
        x_q <= AW'(X0);
        z_q <= {op_a_i, {G{1'b0}}};
      end
    end else if (busy) begin
      if (is_mul) begin
        x_q <= s2 >>> 2;
        y_q <= lo_nxt;
        z_q <= z_q >>> RET;
      end else begin
        x_q <= s0;
        y_q <= s1;
        z_q <= s2;
      end
    end
  end

  assign busy_o = busy;
  assign prod_o = {x_q[DW-1:0], y_q[DW-1:0]};
  assign cos_o  = x_q[AW-1:G];
  assign sin_o  = y_q[AW-1:G];

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !load) |=> ($stable(prod_o) && $stable(cos_o) && $stable(sin_o))); // R9
  AST_ANGLE_RESIDUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !is_mul) |-> (z_q < 64 && z_q > -64)); // R5
  AST_LOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> busy); // R2
endmodule

// File: tb/tb_cordic_mul_unit.sv
module tb_cordic_mul_unit;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic signed [17:0] op_a_i = '0;
  logic signed [17:0] op_b_i = '0;
  logic busy_o, done_o;
  logic [35:0] prod_o;
  logic [17:0] cos_o, sin_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  cordic_mul_unit dut (
    .clk_i, .rst_ni, .start_i, .mode_i, .op_a_i, .op_b_i,
    .busy_o, .done_o, .prod_o, .cos_o, .sin_o
  );

  always #10 clk_i = ~clk_i;   // 50 MHz

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp<150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // start on a falling edge, count falling edges until done
  task automatic run_op(input logic md, input logic signed [17:0] a, input logic signed [17:0] b,
                        input bit poke, output int lat);
    start_i = 1'b1; mode_i = md; op_a_i = a; op_b_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    chk(busy_o === 1'b1, "R2 busy after start", longint'(busy_o), 1);
    while (!done_o && lat < 100) begin
      if (poke && lat == 1) begin
        start_i = 1'b1; mode_i = ~md; op_a_i = ~a; op_b_i = ~b;   // R8 ignored
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      lat++;
    end
    start_i = 1'b0;
    chk(busy_o === 1'b0, "R7 busy low with done", longint'(busy_o), 0);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R7 done single cycle", longint'(done_o), 0);
  endtask

  task automatic do_mul(input logic signed [17:0] a, input logic signed [17:0] b, input bit poke);
    int lat;
    longint exp;
    run_op(1'b1, a, b, poke, lat);
    exp = longint'(a) * longint'(b);
    chk(lat == 3, poke ? "R8 R4 latency" : "R4 latency", lat, 3);
    chk(longint'($signed(prod_o)) == exp, poke ? "R8 R3 product" : "R3 product",
        longint'($signed(prod_o)), exp);
  endtask

  task automatic do_rot(input logic signed [17:0] ang);
    int lat, ec, es, ac, as_;
    real th;
    run_op(1'b0, ang, 18'sd0, 1'b0, lat);
    th = real'(ang) * 3.14159265358979 / 131072.0;
    ec = int'($cos(th) * 65536.0);
    es = int'($sin(th) * 65536.0);
    ac = int'($signed(cos_o));
    as_ = int'($signed(sin_o));
    chk(lat == 16, "R6 latency", lat, 16);
    chk(ac - ec <= 4 && ec - ac <= 4, "R5 cosine", ac, ec);
    chk(as_ - es <= 4 && es - as_ <= 4, "R5 sine", as_, es);
  endtask

  initial begin
    logic [35:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R1 flags in reset", longint'({busy_o, done_o}), 0);
    chk(prod_o === '0 && cos_o === '0 && sin_o === '0, "R1 results in reset",
        longint'(prod_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R1 idle after reset", longint'({busy_o, done_o}), 0);

    // multiply corners
    do_mul(18'sd0, 18'sd0, 1'b0);
    do_mul(18'sd1, -18'sd1, 1'b0);
    do_mul(-18'sd131072, -18'sd131072, 1'b0);
    do_mul(-18'sd131072, 18'sd131071, 1'b0);
    do_mul(18'sd131071, 18'sd131071, 1'b0);
    do_mul(-18'sd131072, 18'sd1, 1'b0);
    do_mul(18'sd12345, -18'sd131072, 1'b0);
    for (int i = 0; i < 40; i++) do_mul(18'($urandom), 18'($urandom), 1'b0);

    // start during busy
    do_mul(18'sd77777, -18'sd4321, 1'b1);
    do_mul(-18'sd131072, -18'sd3, 1'b1);

    // hold after idle cycles
    held = prod_o;
    repeat (6) @(negedge clk_i);
    chk(prod_o === held, "R9 product hold", longint'(prod_o), longint'(held));

    // rotation corners
    do_rot(18'sd0);
    do_rot(18'sd65536);
    do_rot(-18'sd65536);
    do_rot(18'sd32768);
    do_rot(-18'sd21845);
    do_rot(18'sd1);
    for (int i = 0; i < 24; i++) do_rot(18'(int'($urandom_range(0, 131072)) - 65536));

    repeat (5) @(negedge clk_i);
    chk(done_o === 1'b0 && busy_o === 1'b0, "R9 idle stays quiet", longint'({busy_o, done_o}), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule